// File: doc/BRIEF.md
# Accumulator Machine Multicycle Core

A small multicycle processor for a 24-bit accumulator instruction set with a 15-bit byte address space. It runs one instruction at a time. It fetches three bytes from a synchronous byte memory and forms a direct or indexed target address. It then reads or writes operand bytes and updates its registers. The registers are an accumulator, an index register, a link register, the program counter and a two-bit condition code kept in the status word.

The core has two ports. The memory port issues one byte request per cycle and gets read data back one cycle later. The device port carries an 8-bit device code, a ready input, one-cycle read and write strobes, and a byte of data each way. The device code is the memory byte at the target address. An unknown opcode stops the core, and it stays stopped until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is low and just after it is released, halt is low and no memory write is issued. The first request is a read of address 0.
- R2: An instruction is three bytes at PC, read at PC, PC+1 and PC+2 in consecutive cycles. The first byte is the opcode. Bit 7 of the second byte is the index flag. The remaining 15 bits, most significant first, are the address field. PC advances by 3.
- R3: The target address equals the address field when the index flag is 0. When the flag is 1 it is the field plus the low 15 bits of X, modulo 2^15.
- R4: A word is three bytes, most significant at the lowest address. Loads (LDA 00, LDX 04, LDL 08) read and stores (STA 0C, STX 10, STL 14) write the three bytes at the target address in ascending order.
- R5: ADD (18) and SUB (1C) combine A with a memory word and leave the result, modulo 2^24, in A.
- R6: COMP (28) compares A with a memory word as signed 24-bit values and sets the code to less (00), equal (01) or greater (10). JLT (38), JEQ (30) and JGT (34) jump to the target only on a matching code. J (3C) always jumps.
- R7: JSUB (48) puts the address of the next instruction into L and jumps to the target. RSUB (4C) jumps to the address held in L.
- R8: TIX (2C) adds 1 to X, then compares the new X with a memory word and sets the code as R6 does.
- R9: LDCH (50) replaces only bits 7:0 of A with the target byte. STCH (54) writes only the target byte, with A[7:0].
- R10: TD (E0) sets the code to less when the device is ready and to equal when it is not. The device code is the memory byte at the target address.
- R11: RD (D8) pulses the read strobe for one cycle and loads the device byte into A[7:0]. WD (DC) pulses the write strobe for one cycle with A[7:0]. Each uses the device code from the target byte.
- R12: Any other opcode raises halt. Once raised, halt stays high and no memory or device request follows.
- R13: Read data arrives the cycle after the read request. A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 15 | Byte address of the current request |
| mem_rd | output | 1 | Read request |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid one cycle after the request |
| dev_code | output | 8 | Selected device |
| dev_ready | input | 1 | Device ready |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_rdata | input | 8 | Byte from the device |
| halt | output | 1 | Stopped on an unknown opcode |

## Verification
The bench targets the places where an off-by-one or a wrong sign would go unnoticed in plain code. A sum that wraps past 2^24 would come out wrong if the adder were narrowed. An indexed address that wraps past 2^15 would land on the wrong data if the carry leaked. Comparing -1 with 1 exposes an unsigned compare, because the core would take the greater branch. The string copy stops after exactly four bytes, so a TIX that compares before its increment copies one byte too many. LDCH and STCH are checked against the neighbouring bits and bytes, which a word-wide path would overwrite. The I/O test runs with the device both ready and not ready, so a swapped TD code takes the wrong branch. After an illegal opcode the bench watches for any stray request and for a store that should never happen.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam logic [7:0] OP_LDA  = 8'h00;
    localparam logic [7:0] OP_LDX  = 8'h04;
    localparam logic [7:0] OP_LDL  = 8'h08;
    localparam logic [7:0] OP_STA  = 8'h0C;
    localparam logic [7:0] OP_STX  = 8'h10;
    localparam logic [7:0] OP_STL  = 8'h14;
    localparam logic [7:0] OP_ADD  = 8'h18;
    localparam logic [7:0] OP_SUB  = 8'h1C;
    localparam logic [7:0] OP_COMP = 8'h28;
    localparam logic [7:0] OP_TIX  = 8'h2C;
    localparam logic [7:0] OP_JEQ  = 8'h30;
    localparam logic [7:0] OP_JGT  = 8'h34;
    localparam logic [7:0] OP_JLT  = 8'h38;
    localparam logic [7:0] OP_J    = 8'h3C;
    localparam logic [7:0] OP_JSUB = 8'h48;
    localparam logic [7:0] OP_RSUB = 8'h4C;
    localparam logic [7:0] OP_LDCH = 8'h50;
    localparam logic [7:0] OP_STCH = 8'h54;
    localparam logic [7:0] OP_RD   = 8'hD8;
    localparam logic [7:0] OP_WD   = 8'hDC;
    localparam logic [7:0] OP_TD   = 8'hE0;

    localparam logic [1:0] CC_LT = 2'b00;
    localparam logic [1:0] CC_EQ = 2'b01;
    localparam logic [1:0] CC_GT = 2'b10;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_READ, ST_EXEC, ST_WRITE, ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        K_LOAD, K_STORE, K_ADD, K_SUB, K_COMP, K_TIX, K_JUMP, K_JSUB,
        K_RSUB, K_LDCH, K_STCH, K_TD, K_RD, K_WD, K_BAD
    } kind_e;

    typedef enum logic [1:0] { R_A, R_X, R_L } regsel_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  logic [7:0] opcode,
    output kind_e      kind,
    output regsel_e    rsel,
    output logic [1:0] jcc,
    output logic       jany,
    output logic       byte_op
);
    always_comb begin
        kind = K_BAD;
        rsel = R_A;
        jcc  = CC_EQ;
        jany = 1'b0;
        unique case (opcode)
            OP_LDA:  kind = K_LOAD;
            OP_LDX:  begin kind = K_LOAD;  rsel = R_X; end
            OP_LDL:  begin kind = K_LOAD;  rsel = R_L; end
            OP_STA:  kind = K_STORE;
            OP_STX:  begin kind = K_STORE; rsel = R_X; end
            OP_STL:  begin kind = K_STORE; rsel = R_L; end
            OP_ADD:  kind = K_ADD;
            OP_SUB:  kind = K_SUB;
            OP_COMP: kind = K_COMP;
            OP_TIX:  kind = K_TIX;
            OP_JEQ:  kind = K_JUMP;
            OP_JGT:  begin kind = K_JUMP; jcc = CC_GT; end
            OP_JLT:  begin kind = K_JUMP; jcc = CC_LT; end
            OP_J:    begin kind = K_JUMP; jany = 1'b1; end
            OP_JSUB: kind = K_JSUB;
            OP_RSUB: kind = K_RSUB;
            OP_LDCH: kind = K_LDCH;
            OP_STCH: kind = K_STCH;
            OP_TD:   kind = K_TD;
            OP_RD:   kind = K_RD;
            OP_WD:   kind = K_WD;
            default: kind = K_BAD;
        endcase
    end

    assign byte_op = (kind == K_LDCH) || (kind == K_STCH) || (kind == K_TD) ||
                     (kind == K_RD) || (kind == K_WD);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] lhs,
    input  logic [WORD_W-1:0] rhs,
    input  logic              sub,
    output logic [WORD_W-1:0] res,
    output logic [1:0]        cc
);
    always_comb begin
        res = sub ? (lhs - rhs) : (lhs + rhs);
        if ($signed(lhs) < $signed(rhs))
            cc = CC_LT;
        else if (lhs == rhs)
            cc = CC_EQ;
        else
            cc = CC_GT;
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        dev_code,
    input  logic              dev_ready,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [7:0]        dev_wdata,
    input  logic [7:0]        dev_rdata,
    output logic              halt
);
    localparam int NB   = WORD_W / 8;
    localparam int CW   = $clog2(NB + 1);
    localparam int XBIT = WORD_W - 9;

    typedef struct packed {
        state_e            st;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic [ADDR_W-1:0] ta;
        logic [WORD_W-1:0] md;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] l;
        logic [1:0]        cc;
    } core_t;

    core_t q, d;

    kind_e             kind;
    regsel_e           rsel;
    logic [1:0]        jcc;
    logic              jany, byte_op;
    logic [WORD_W-1:0] alu_lhs, alu_res, store_val, store_sh;
    logic [1:0]        alu_cc;
    logic [CW-1:0]     nbytes;
    logic [ADDR_W-1:0] ta_calc, base;

    acc_decode u_dec (
        .opcode (q.ir[WORD_W-1 -: 8]),
        .kind   (kind),
        .rsel   (rsel),
        .jcc    (jcc),
        .jany   (jany),
        .byte_op(byte_op)
    );

    assign alu_lhs = (kind == K_TIX) ? (q.x + WORD_W'(1)) : q.a;

    acc_alu #(.WORD_W(WORD_W)) u_alu (
        .lhs(alu_lhs),
        .rhs(q.md),
        .sub(kind == K_SUB),
        .res(alu_res),
        .cc (alu_cc)
    );

    assign nbytes  = byte_op ? CW'(1) : CW'(NB);
    assign ta_calc = q.ir[ADDR_W-1:0] + (q.ir[XBIT] ? q.x[ADDR_W-1:0] : '0);
    assign base    = (q.st == ST_FETCH) ? q.pc : q.ta;

    always_comb begin
        unique case (rsel)
            R_X:     store_val = q.x;
            R_L:     store_val = q.l;
            default: store_val = q.a;
        endcase
        store_sh = store_val << (8 * int'(q.cnt));
    end

    assign mem_addr  = base + ADDR_W'(q.cnt);
    assign dev_code  = q.md[7:0];
    assign dev_wdata = q.a[7:0];
    assign halt      = (q.st == ST_HALT);

    always_comb begin
        d         = q;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        dev_rd    = 1'b0;
        dev_wr    = 1'b0;
        unique case (q.st)
            ST_FETCH: begin
                mem_rd = (q.cnt < CW'(NB));
                if (q.cnt != '0) d.ir = {q.ir[WORD_W-9:0], mem_rdata};
                if (q.cnt == CW'(NB)) begin
                    d.st  = ST_DECODE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_DECODE: begin
                d.pc  = q.pc + ADDR_W'(NB);
                d.ta  = ta_calc;
                d.cnt = '0;
                unique case (kind)
                    K_BAD:  d.st = ST_HALT;
                    K_JUMP: begin
                        if (jany || (q.cc == jcc)) d.pc = ta_calc;
                        d.st = ST_FETCH;
                    end
                    K_JSUB: begin
                        d.l  = WORD_W'(q.pc + ADDR_W'(NB));
                        d.pc = ta_calc;
                        d.st = ST_FETCH;
                    end
                    K_RSUB: begin
                        d.pc = q.l[ADDR_W-1:0];
                        d.st = ST_FETCH;
                    end
                    K_STORE, K_STCH: d.st = ST_WRITE;
                    default:         d.st = ST_READ;
                endcase
            end
            ST_READ: begin
                mem_rd = (q.cnt < nbytes);
                if (q.cnt != '0) d.md = {q.md[WORD_W-9:0], mem_rdata};
                if (q.cnt == nbytes) begin
                    d.st  = ST_EXEC;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_EXEC: begin
                d.st = ST_FETCH;
                unique case (kind)
                    K_LOAD: begin
                        unique case (rsel)
                            R_X:     d.x = q.md;
                            R_L:     d.l = q.md;
                            default: d.a = q.md;
                        endcase
                    end
                    K_ADD, K_SUB: d.a = alu_res;
                    K_COMP:       d.cc = alu_cc;
                    K_TIX: begin
                        d.x  = alu_lhs;
                        d.cc = alu_cc;
                    end
                    K_LDCH: d.a[7:0] = q.md[7:0];
                    K_TD:   d.cc = dev_ready ? CC_LT : CC_EQ;
                    K_RD: begin
                        dev_rd   = 1'b1;
                        d.a[7:0] = dev_rdata;
                    end
                    K_WD:    dev_wr = 1'b1;
                    default: ;
                endcase
            end
            ST_WRITE: begin
                mem_we    = 1'b1;
                mem_wdata = (kind == K_STCH) ? q.a[7:0] : store_sh[WORD_W-1 -: 8];
                if (q.cnt == nbytes - CW'(1)) begin
                    d.st  = ST_FETCH;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_FETCH;
            q.cc <= CC_EQ;
        end else begin
            q <= d;
        end
    end

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we)); // R13
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt); // R12
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !(mem_rd || mem_we || dev_rd || dev_wr)); // R12
    AST_DEV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_rd, dev_wr})); // R11
    AST_WORD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1))); // R4
    AST_CC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cc != 2'b11); // R6
endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] mem_addr;
    logic        mem_rd, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  dev_code;
    logic        dev_ready = 1'b0;
    logic        dev_rd, dev_wr;
    logic [7:0]  dev_wdata;
    logic [7:0]  dev_rdata = 8'h00;
    logic        halt;

    logic [7:0] mem [0:1023];
    int tests = 0, fails = 0;
    int overlap = 0, wr_cnt = 0, rd_cnt = 0;
    logic [7:0] wr_code, wr_data, rd_code;
    bit done = 0;

    always #5 clk = ~clk;

    acc_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_code(dev_code), .dev_ready(dev_ready), .dev_rd(dev_rd),
        .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .halt(halt)
    );

    always @(posedge clk) begin
        if (rst_n && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
        if (rst_n && mem_rd && mem_we) overlap++;
        if (rst_n && dev_wr) begin wr_cnt++; wr_code <= dev_code; wr_data <= dev_wdata; end
        if (rst_n && dev_rd) begin rd_cnt++; rd_code <= dev_code; end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ins(input logic [7:0] op, input logic x, input logic [14:0] a);
        return {op, x, a};
    endfunction

    task automatic put_w(input int a, input logic [23:0] w);
        mem[a] = w[23:16]; mem[a+1] = w[15:8]; mem[a+2] = w[7:0];
    endtask

    function automatic logic [23:0] get_w(input int a);
        return {mem[a], mem[a+1], mem[a+2]};
    endfunction

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        wr_cnt = 0; rd_cnt = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run(input string req);
        int n = 0;
        rst_n = 1'b1;
        while (!halt && n < 3000) begin @(negedge clk); n++; end
        chk(req, "program reached halt", {31'd0, halt}, 32'd1);
    endtask

    task automatic t_reset();
        hold_reset();
        chk("R1", "halt in reset", {31'd0, halt}, 32'd0);
        chk("R1", "write in reset", {31'd0, mem_we}, 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1", "first addr", {17'd0, mem_addr}, 32'd0);
        chk("R1", "first read", {31'd0, mem_rd}, 32'd1);
        @(negedge clk);
        chk("R2", "second fetch addr", {17'd0, mem_addr}, 32'd1);
        @(negedge clk);
        chk("R2", "third fetch addr", {17'd0, mem_addr}, 32'd2);
        @(negedge clk);
        chk("R13", "no read while last byte lands", {31'd0, mem_rd}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R12", "illegal FF halts", {31'd0, halt}, 32'd1);
    endtask

    task automatic t_arith();
        hold_reset();
        put_w(0, ins(8'h00, 0, 15'h100));
        put_w(3, ins(8'h18, 0, 15'h103));
        put_w(6, ins(8'h1C, 0, 15'h106));
        put_w(9, ins(8'h0C, 0, 15'h109));
        put_w(12, 24'hFF0000);
        put_w(15'h100, 24'h123456);
        put_w(15'h103, 24'hFFFFF0);
        put_w(15'h106, 24'h000046);
        run("R5");
        chk("R5", "add wrap then sub", {8'd0, get_w(15'h109)}, 32'h123400);
        chk("R4", "byte after stored word", {24'd0, mem[15'h10C]}, 32'hFF);
    endtask

    task automatic t_regs();
        hold_reset();
        put_w(0, ins(8'h04, 0, 15'h100));
        put_w(3, ins(8'h10, 0, 15'h103));
        put_w(6, ins(8'h08, 0, 15'h106));
        put_w(9, ins(8'h14, 0, 15'h109));
        put_w(15'h100, 24'hA1B2C3);
        put_w(15'h106, 24'h0F1E2D);
        run("R4");
        chk("R4", "LDX/STX word", {8'd0, get_w(15'h103)}, 32'hA1B2C3);
        chk("R4", "LDL/STL word", {8'd0, get_w(15'h109)}, 32'h0F1E2D);
    endtask

    task automatic t_index();
        hold_reset();
        put_w(0, ins(8'h04, 0, 15'h180));
        put_w(3, ins(8'h00, 1, 15'h7F00));
        put_w(6, ins(8'h0C, 0, 15'h210));
        put_w(15'h180, 24'h000200);
        put_w(15'h100, 24'h5A5A01);
        run("R3");
        chk("R3", "indexed address wraps", {8'd0, get_w(15'h210)}, 32'h5A5A01);
        hold_reset();
        put_w(0, ins(8'h04, 0, 15'h180));
        put_w(3, ins(8'h00, 1, 15'h1F0));
        put_w(6, ins(8'h0C, 0, 15'h200));
        put_w(15'h180, 24'h000006);
        put_w(15'h1F0, 24'h111111);
        put_w(15'h1F6, 24'hABCDEF);
        run("R3");
        chk("R3", "indexed load", {8'd0, get_w(15'h200)}, 32'hABCDEF);
    endtask

    task automatic t_comp(input logic [23:0] av, input logic [23:0] bv, input logic [23:0] exp, input string what);
        hold_reset();
        put_w(0, ins(8'h00, 0, 15'h100));
        put_w(3, ins(8'h28, 0, 15'h103));
        put_w(6, ins(8'h38, 0, 15'h30));
        put_w(9, ins(8'h30, 0, 15'h40));
        put_w(12, ins(8'h34, 0, 15'h50));
        put_w(15'h30, ins(8'h00, 0, 15'h106));
        put_w(15'h33, ins(8'h0C, 0, 15'h10F));
        put_w(15'h40, ins(8'h00, 0, 15'h109));
        put_w(15'h43, ins(8'h0C, 0, 15'h10F));
        put_w(15'h50, ins(8'h00, 0, 15'h10C));
        put_w(15'h53, ins(8'h0C, 0, 15'h10F));
        put_w(15'h100, av);
        put_w(15'h103, bv);
        put_w(15'h106, 24'h000011);
        put_w(15'h109, 24'h000022);
        put_w(15'h10C, 24'h000033);
        run("R6");
        chk("R6", what, {8'd0, get_w(15'h10F)}, {8'd0, exp});
    endtask

    task automatic t_sub();
        hold_reset();
        put_w(0, ins(8'h48, 0, 15'h40));
        put_w(3, ins(8'h00, 0, 15'h103));
        put_w(6, ins(8'h0C, 0, 15'h106));
        put_w(15'h40, ins(8'h14, 0, 15'h109));
        put_w(15'h43, ins(8'h00, 0, 15'h100));
        put_w(15'h46, ins(8'h0C, 0, 15'h10C));
        put_w(15'h49, ins(8'h3C, 0, 15'h60));
        put_w(15'h60, ins(8'h4C, 0, 15'h0));
        put_w(15'h100, 24'h777777);
        put_w(15'h103, 24'h000099);
        run("R7");
        chk("R7", "link holds return address", {8'd0, get_w(15'h109)}, 32'h000003);
        chk("R7", "subroutine body ran", {8'd0, get_w(15'h10C)}, 32'h777777);
        chk("R7", "resumed after RSUB via J", {8'd0, get_w(15'h106)}, 32'h000099);
    endtask

    task automatic t_tix();
        hold_reset();
        put_w(0, ins(8'h04, 0, 15'h100));
        put_w(3, ins(8'h50, 1, 15'h110));
        put_w(6, ins(8'h54, 1, 15'h120));
        put_w(9, ins(8'h2C, 0, 15'h103));
        put_w(12, ins(8'h38, 0, 15'h3));
        put_w(15, ins(8'h10, 0, 15'h106));
        put_w(15'h100, 24'h000000);
        put_w(15'h103, 24'h000004);
        for (int i = 0; i < 5; i++) mem[15'h110 + i] = 8'h41 + 8'(i);
        run("R8");
        for (int i = 0; i < 4; i++)
            chk("R8", "copied byte", {24'd0, mem[15'h120 + i]}, {24'd0, 8'h41 + 8'(i)});
        chk("R8", "loop stops at limit", {24'd0, mem[15'h124]}, 32'hFF);
        chk("R8", "final X", {8'd0, get_w(15'h106)}, 32'h000004);
    endtask

    task automatic t_byte();
        hold_reset();
        put_w(0, ins(8'h00, 0, 15'h130));
        put_w(3, ins(8'h50, 0, 15'h133));
        put_w(6, ins(8'h0C, 0, 15'h136));
        put_w(9, ins(8'h54, 0, 15'h141));
        put_w(15'h130, 24'h123456);
        mem[15'h133] = 8'h9A;
        run("R9");
        chk("R9", "LDCH keeps upper A", {8'd0, get_w(15'h136)}, 32'h12349A);
        chk("R9", "STCH byte", {24'd0, mem[15'h141]}, 32'h9A);
        chk("R9", "STCH neighbour below", {24'd0, mem[15'h140]}, 32'hFF);
        chk("R9", "STCH neighbour above", {24'd0, mem[15'h142]}, 32'hFF);
    endtask

    task automatic t_io(input logic rdy);
        hold_reset();
        dev_ready = rdy;
        dev_rdata = 8'h6B;
        put_w(0, ins(8'hE0, 0, 15'h100));
        put_w(3, ins(8'h30, 0, 15'h30));
        put_w(6, ins(8'hD8, 0, 15'h100));
        put_w(9, ins(8'h54, 0, 15'h110));
        put_w(12, ins(8'h50, 0, 15'h111));
        put_w(15, ins(8'hDC, 0, 15'h101));
        put_w(15'h30, ins(8'h00, 0, 15'h104));
        put_w(15'h33, ins(8'h0C, 0, 15'h108));
        mem[15'h100] = 8'h05;
        mem[15'h101] = 8'h07;
        mem[15'h111] = 8'hC3;
        put_w(15'h104, 24'h0000EE);
        run("R10");
        if (rdy) begin
            chk("R10", "ready device skips wait path", {8'd0, get_w(15'h108)}, 32'hFFFFFF);
            chk("R11", "RD byte stored", {24'd0, mem[15'h110]}, 32'h6B);
            chk("R11", "RD strobes", rd_cnt, 32'd1);
            chk("R11", "RD device code", {24'd0, rd_code}, 32'h05);
            chk("R11", "WD strobes", wr_cnt, 32'd1);
            chk("R11", "WD device code", {24'd0, wr_code}, 32'h07);
            chk("R11", "WD data", {24'd0, wr_data}, 32'hC3);
        end else begin
            chk("R10", "busy device takes equal path", {8'd0, get_w(15'h108)}, 32'h0000EE);
            chk("R10", "no read when busy", rd_cnt, 32'd0);
            chk("R10", "no write when busy", wr_cnt, 32'd0);
        end
        dev_ready = 1'b0;
    endtask

    task automatic t_halt();
        int act = 0;
        hold_reset();
        put_w(0, ins(8'h00, 0, 15'h100));
        put_w(3, ins(8'h44, 0, 15'h0));
        put_w(6, ins(8'h0C, 0, 15'h103));
        put_w(15'h100, 24'h010203);
        run("R12");
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_rd || mem_we || dev_rd || dev_wr || !halt) act++;
        end
        chk("R12", "quiet and held after halt", act, 32'd0);
        chk("R12", "no store after illegal opcode", {8'd0, get_w(15'h103)}, 32'hFFFFFF);
        chk("R13", "read/write overlap count", overlap, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_arith();
        t_regs();
        t_index();
        t_comp(24'h000001, 24'h000002, 24'h000011, "less");
        t_comp(24'h000005, 24'h000005, 24'h000022, "equal");
        t_comp(24'h000009, 24'h000002, 24'h000033, "greater");
        t_comp(24'hFFFFFF, 24'h000001, 24'h000011, "signed -1 < 1");
        t_comp(24'h000001, 24'hFFFFFF, 24'h000033, "signed 1 > -1");
        t_sub();
        t_tix();
        t_byte();
        t_io(1'b1);
        t_io(1'b0);
        t_halt();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule